// File: doc/BRIEF.md
# Receive Word FIFO with Programmable Level Flags

This block buffers 32-bit words arriving on a parallel input port and hands them to a host through a small word-addressed register interface. When the receive path is enabled, a word is captured on every clock in which the port strobe is high. The host removes words one at a time by reading the data register. Status is reported through four level flags, all in inverted sense: not-empty, not-almost-empty, not-almost-full and not-full. The same register holds two sticky error bits, one for a word lost to a full FIFO and one for a read of an empty FIFO.

Two programmable levels set where the almost-empty and almost-full flags switch. The fields that hold them differ in width: the almost-empty level is 16 bits and the almost-full level is 8 bits. Read-only registers give the FIFO capacity and the live word count. The control register has three actions. A FIFO reset flushes the stored words. A board reset flushes the words, restores every default and then starts a settling interval of 10 µs, counted on a 20 MHz clock by default. During that interval the FIFO is neither filled nor drained.

Register offsets (word addresses): 0 control, 1 status, 2 levels, 3 data, 4 capacity, 5 count.

Top module: `rxfifo_ctl`

## Requirements
- R1: After rst_n, status reads 0x0000_C000, the level register reads 0x0020_0020, control reads 0 and count reads 0.
- R2: Control bit 5 is the receive enable and reads back. A port word with port_valid_i high is stored only while it is 1 and no settling interval is running; otherwise the word is dropped.
- R3: A read of the data register removes the oldest word, so words leave in arrival order. Every register read places its value on reg_rdata_o at the clock edge that samples reg_rd_i, and reg_rdata_o holds that value until the next read.
- R4: Status bit 12 is 1 when the count is nonzero. Status bit 15 is 1 when the count is below DEPTH.
- R5: Status bit 13 is 1 when the count is greater than the almost-empty level, which is level register bits 15:0.
- R6: Status bit 14 is 1 when the free space (DEPTH minus count) is greater than the almost-full level, which is level register bits 23:16.
- R7: A port word that arrives while the count equals DEPTH is dropped and sets status bit 23.
- R8: A data read while the FIFO is empty leaves the count unchanged, returns the last word read and sets status bit 22.
- R9: Status bits 22 and 23 stay set until a write to the status register carries a 1 in that bit position. A 0 in that position leaves the bit unchanged.
- R10: A control write with bit 2 set and bit 0 clear empties the FIFO and clears bits 22 and 23. It keeps both levels, and the receive enable takes bit 5 of the same write.
- R11: A control write with bit 0 set empties the FIFO, clears both error bits, loads 32 into both levels and clears the receive enable. For the next CLK_MHZ*SETTLE_US cycles, port words are dropped, and data reads remove nothing and set no error.
- R12: Capacity register bits 19:0 read DEPTH. The count register reads the current word count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_valid_i | input | 1 | Input port word strobe |
| port_data_i | input | DW | Input port word |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |

## Verification
A port word that is strobed at one clock edge appears in the count and the flags that a read sampled at the next edge reports. A register read returns its value at the edge that samples the strobe, and a popped word is likewise visible at that same edge. The bench changes every input at a falling edge and samples reg_rdata_o at the falling edge that follows the sampling rising edge. A scoreboard queue holds the words the bench model expects to be accepted; a monitor compares each data-register result one half cycle after the edge that captured the read.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;

    localparam int REG_AW = 3;

    // register word addresses
    localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] A_STAT = 3'd1;
    localparam logic [REG_AW-1:0] A_LVL  = 3'd2;
    localparam logic [REG_AW-1:0] A_DATA = 3'd3;
    localparam logic [REG_AW-1:0] A_CAP  = 3'd4;
    localparam logic [REG_AW-1:0] A_CNT  = 3'd5;

    // control bit positions
    localparam int B_BRST = 0;
    localparam int B_FRST = 2;
    localparam int B_RXEN = 5;

    // status bit positions
    localparam int B_NE   = 12;
    localparam int B_NAE  = 13;
    localparam int B_NAF  = 14;
    localparam int B_NF   = 15;
    localparam int B_UNF  = 22;
    localparam int B_OVF  = 23;

    // level field widths and reset value
    localparam int AE_W      = 16;
    localparam int AF_W      = 8;
    localparam int AF_LSB    = 16;
    localparam int CAP_W     = 20;
    localparam int LVL_RESET = 32;

    typedef struct packed {
        logic nf;
        logic naf;
        logic nae;
        logic ne;
    } lvl_flags_t;

endpackage

// File: rtl/rxfifo_flags.sv
module rxfifo_flags
    import rxfifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0]   count_i,
    input  logic [AE_W-1:0] ae_lvl_i,
    input  logic [AF_W-1:0] af_lvl_i,
    output lvl_flags_t      flags_o
);

    logic [31:0] used_w;
    logic [31:0] free_w;

    always_comb begin
        used_w        = 32'(count_i);
        free_w        = 32'(DEPTH) - used_w;
        flags_o.ne    = (used_w != 32'd0);
        flags_o.nae   = (used_w > 32'(ae_lvl_i));
        flags_o.naf   = (free_w > 32'(af_lvl_i));
        flags_o.nf    = (used_w != 32'(DEPTH));
    end

endmodule

// File: rtl/rxfifo_store.sv
module rxfifo_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] data_i,
    input  logic          pop_i,
    input  logic          flush_i,
    output logic [CW-1:0] count_o,
    output logic [DW-1:0] head_o,
    output logic          ovf_o,
    output logic          unf_o
);

    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam bit POW2 = (DEPTH == (1 << AW));

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } st_t;

    st_t           st_d, st_q;
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_nx, rd_nx;
    logic          full, empty, do_push, do_pop;

    generate
        if (POW2) begin : g_pow2
            assign wr_nx = st_q.wr + AW'(1);
            assign rd_nx = st_q.rd + AW'(1);
        end else begin : g_wrap
            assign wr_nx = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + AW'(1);
            assign rd_nx = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + AW'(1);
        end
    endgenerate

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign do_push = push_i && !full && !flush_i;
    assign do_pop  = pop_i && !empty && !flush_i;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = wr_nx;
            if (do_pop)  st_d.rd = rd_nx;
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr] <= data_i;
    end

    assign head_o  = mem[st_q.rd];
    assign count_o = st_q.cnt;
    assign ovf_o   = push_i && full && !flush_i;
    assign unf_o   = pop_i && empty && !flush_i;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)) else $error("count above depth"); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (st_q.cnt == '0)) else $error("flush left words"); // R10
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty) |=> (st_q.cnt == '0)) else $error("empty pop moved count"); // R8
    AST_FULL_PUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !flush_i && full) |=> full) else $error("full push changed count"); // R7

endmodule

// File: rtl/rxfifo_csr.sv
module rxfifo_csr
    import rxfifo_pkg::*;
#(
    parameter int DW            = 32,
    parameter int DEPTH         = 64,
    parameter int CW            = $clog2(DEPTH + 1),
    parameter int SETTLE_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic              port_valid_i,
    input  logic [CW-1:0]     count_i,
    input  logic [DW-1:0]     head_i,
    input  lvl_flags_t        flags_i,
    input  logic              ovf_evt_i,
    input  logic              unf_evt_i,
    output logic              push_o,
    output logic              pop_o,
    output logic              flush_o,
    output logic [AE_W-1:0]   ae_lvl_o,
    output logic [AF_W-1:0]   af_lvl_o
);

    localparam int SW = (SETTLE_CYCLES > 0) ? $clog2(SETTLE_CYCLES + 1) : 1;

    typedef struct packed {
        logic            rx_en;
        logic [AE_W-1:0] ae;
        logic [AF_W-1:0] af;
        logic            ovf;
        logic            unf;
        logic [SW-1:0]   settle;
        logic [31:0]     rdata;
        logic [DW-1:0]   last;
    } csr_t;

    csr_t        st_d, st_q;
    logic        ctrl_wr, stat_wr, lvl_wr, brst, frst, settling, data_rd;
    logic [31:0] stat_w, ctrl_w, data_w;
    logic        unused_wbits;

    assign unused_wbits = ^reg_wdata_i[31:24];

    always_comb begin
        ctrl_wr  = reg_wr_i && (reg_addr_i == A_CTRL);
        stat_wr  = reg_wr_i && (reg_addr_i == A_STAT);
        lvl_wr   = reg_wr_i && (reg_addr_i == A_LVL);
        brst     = ctrl_wr && reg_wdata_i[B_BRST];
        frst     = ctrl_wr && reg_wdata_i[B_FRST] && !brst;
        settling = (st_q.settle != '0);
        data_rd  = reg_rd_i && (reg_addr_i == A_DATA);

        push_o   = port_valid_i && st_q.rx_en && !settling;
        pop_o    = data_rd && !settling;
        flush_o  = brst || frst;

        stat_w         = '0;
        stat_w[B_NE]   = flags_i.ne;
        stat_w[B_NAE]  = flags_i.nae;
        stat_w[B_NAF]  = flags_i.naf;
        stat_w[B_NF]   = flags_i.nf;
        stat_w[B_UNF]  = st_q.unf;
        stat_w[B_OVF]  = st_q.ovf;

        ctrl_w         = '0;
        ctrl_w[B_RXEN] = st_q.rx_en;

        data_w = (settling || (count_i == '0)) ? 32'(st_q.last) : 32'(head_i);

        st_d = st_q;

        if (settling) st_d.settle = st_q.settle - SW'(1);
        if (ctrl_wr)  st_d.rx_en  = reg_wdata_i[B_RXEN];
        if (lvl_wr) begin
            st_d.ae = reg_wdata_i[AE_W-1:0];
            st_d.af = reg_wdata_i[AF_LSB +: AF_W];
        end
        if (stat_wr && reg_wdata_i[B_UNF]) st_d.unf = 1'b0;
        if (stat_wr && reg_wdata_i[B_OVF]) st_d.ovf = 1'b0;
        if (ovf_evt_i) st_d.ovf = 1'b1;
        if (unf_evt_i) st_d.unf = 1'b1;
        if (frst) begin
            st_d.ovf = 1'b0;
            st_d.unf = 1'b0;
        end
        if (brst) begin
            st_d.rx_en  = 1'b0;
            st_d.ae     = AE_W'(LVL_RESET);
            st_d.af     = AF_W'(LVL_RESET);
            st_d.ovf    = 1'b0;
            st_d.unf    = 1'b0;
            st_d.settle = SW'(SETTLE_CYCLES);
        end

        if (reg_rd_i) begin
            case (reg_addr_i)
                A_CTRL:  st_d.rdata = ctrl_w;
                A_STAT:  st_d.rdata = stat_w;
                A_LVL:   st_d.rdata = {8'd0, st_q.af, st_q.ae};
                A_DATA:  st_d.rdata = data_w;
                A_CAP:   st_d.rdata = {{(32 - CAP_W){1'b0}}, CAP_W'(DEPTH)};
                A_CNT:   st_d.rdata = 32'(count_i);
                default: st_d.rdata = '0;
            endcase
        end

        if (pop_o && (count_i != '0)) st_d.last = head_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ae <= AE_W'(LVL_RESET);
            st_q.af <= AF_W'(LVL_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata_o = st_q.rdata;
    assign ae_lvl_o    = st_q.ae;
    assign af_lvl_o    = st_q.af;

    AST_OVF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt_i && !flush_o) |=> st_q.ovf) else $error("overrun not latched"); // R7
    AST_UNF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_evt_i && !flush_o) |=> st_q.unf) else $error("underrun not latched"); // R8
    AST_W1C_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !(stat_wr && reg_wdata_i[B_OVF]) && !flush_o) |=> st_q.ovf)
        else $error("overrun dropped without clear"); // R9
    AST_BRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        brst |=> (st_q.ae == AE_W'(LVL_RESET) && st_q.af == AF_W'(LVL_RESET) && !st_q.rx_en))
        else $error("board reset defaults"); // R11
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_i |=> $stable(reg_rdata_o)) else $error("read data moved"); // R3

endmodule

// File: rtl/rxfifo_ctl.sv
module rxfifo_ctl
    import rxfifo_pkg::*;
#(
    parameter int DW        = 32,
    parameter int DEPTH     = 64,
    parameter int CLK_MHZ   = 20,
    parameter int SETTLE_US = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_valid_i,
    input  logic [DW-1:0]     port_data_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o
);

    localparam int CW            = $clog2(DEPTH + 1);
    localparam int SETTLE_CYCLES = CLK_MHZ * SETTLE_US;

    logic [CW-1:0]   count_w;
    logic [DW-1:0]   head_w;
    logic            push_w, pop_w, flush_w, ovf_w, unf_w;
    logic [AE_W-1:0] ae_w;
    logic [AF_W-1:0] af_w;
    lvl_flags_t      flags_w;

    rxfifo_csr #(
        .DW(DW), .DEPTH(DEPTH), .CW(CW), .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_csr (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .port_valid_i(port_valid_i), .count_i(count_w), .head_i(head_w),
        .flags_i(flags_w), .ovf_evt_i(ovf_w), .unf_evt_i(unf_w),
        .push_o(push_w), .pop_o(pop_w), .flush_o(flush_w),
        .ae_lvl_o(ae_w), .af_lvl_o(af_w)
    );

    rxfifo_store #(
        .DW(DW), .DEPTH(DEPTH), .CW(CW)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_w), .data_i(port_data_i), .pop_i(pop_w), .flush_i(flush_w),
        .count_o(count_w), .head_o(head_w), .ovf_o(ovf_w), .unf_o(unf_w)
    );

    rxfifo_flags #(
        .DEPTH(DEPTH), .CW(CW)
    ) u_flags (
        .count_i(count_w), .ae_lvl_i(ae_w), .af_lvl_i(af_w), .flags_o(flags_w)
    );

    AST_FULL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (count_w == CW'(DEPTH)) |-> (!flags_w.nf && flags_w.ne))
        else $error("full flags wrong"); // R4
    AST_COUNT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_w && !pop_w && !flush_w) |=> $stable(count_w))
        else $error("count moved with no request"); // R12

endmodule

// File: tb/rxfifo_ctl_tb_top.sv
module rxfifo_ctl_tb_top;
    import rxfifo_pkg::*;

    localparam int DEPTH  = 64;
    localparam int SETTLE = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_valid = 1'b0;
    logic [31:0] port_data = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    always #10 clk = ~clk;

    rxfifo_ctl #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .port_valid_i(port_valid), .port_data_i(port_data),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] exp_q[$];
    logic        m_en = 1'b0, m_ovf = 1'b0, m_unf = 1'b0, m_settle = 1'b0;
    int          m_ae = 32, m_af = 32;
    logic [31:0] m_last = '0;
    logic [31:0] exp_word;
    logic        pend = 1'b0;
    logic [31:0] v;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat();
        logic [31:0] s;
        int n;
        n = exp_q.size();
        s = '0;
        s[12] = (n != 0);
        s[13] = (n > m_ae);
        s[14] = ((DEPTH - n) > m_af);
        s[15] = (n != DEPTH);
        s[22] = m_unf;
        s[23] = m_ovf;
        return s;
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] r);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        r = reg_rdata;
    endtask

    task automatic ctrl_write(input logic [31:0] d);
        wr_reg(A_CTRL, d);
        if (d[0]) begin
            exp_q.delete();
            m_en = 1'b0; m_ae = 32; m_af = 32;
            m_ovf = 1'b0; m_unf = 1'b0; m_settle = 1'b1;
        end else begin
            m_en = d[5];
            if (d[2]) begin
                exp_q.delete();
                m_ovf = 1'b0; m_unf = 1'b0;
            end
        end
    endtask

    // driver: pushes the expected word into the scoreboard when accepted
    task automatic push_word(input logic [31:0] d);
        @(negedge clk);
        port_valid = 1'b1; port_data = d;
        if (m_en && !m_settle) begin
            if (exp_q.size() < DEPTH) exp_q.push_back(d);
            else m_ovf = 1'b1;
        end
        @(negedge clk);
        port_valid = 1'b0;
    endtask

    // monitor: compares each data-register result against the scoreboard
    always @(posedge clk) pend <= reg_rd && (reg_addr == A_DATA);

    always @(negedge clk) begin
        if (pend) begin
            if (m_settle) begin
                check("R11 data read while settling", reg_rdata, m_last);
            end else if (exp_q.size() == 0) begin
                check("R8 empty read returns last word", reg_rdata, m_last);
                m_unf = 1'b1;
            end else begin
                exp_word = exp_q.pop_front();
                check("R3 arrival order", reg_rdata, exp_word);
                m_last = exp_word;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(A_STAT, v); check("R1 status", v, 32'h0000_C000);
        rd_reg(A_LVL, v);  check("R1 levels", v, 32'h0020_0020);
        rd_reg(A_CTRL, v); check("R1 control", v, 32'h0);
        rd_reg(A_CNT, v);  check("R1 count", v, 32'h0);
        rd_reg(A_CAP, v);  check("R12 capacity", v, 32'(DEPTH));

        // R2 words dropped while disabled
        for (int i = 0; i < 3; i++) push_word(32'hD000_0000 + i);
        rd_reg(A_CNT, v); check("R2 disabled drop", v, 32'h0);

        wr_reg(A_LVL, 32'h0003_0002); m_ae = 2; m_af = 3;
        rd_reg(A_LVL, v); check("R5 level readback", v, 32'h0003_0002);
        ctrl_write(32'h20);
        rd_reg(A_CTRL, v); check("R2 enable readback", v, 32'h20);

        // R5 almost-empty boundary
        for (int i = 0; i < 2; i++) push_word(32'hA000_0000 + i);
        rd_reg(A_STAT, v); check("R5 count at level", v, exp_stat());
        push_word(32'hA000_0002);
        rd_reg(A_STAT, v); check("R5 count above level", v, exp_stat());

        // R6 almost-full boundary
        for (int i = 3; i < 60; i++) push_word(32'hA000_0000 + i);
        rd_reg(A_STAT, v); check("R6 free above level", v, exp_stat());
        push_word(32'hA000_003C);
        rd_reg(A_STAT, v); check("R6 free at level", v, exp_stat());
        rd_reg(A_CNT, v);  check("R12 count", v, 32'd61);
        for (int i = 61; i < 64; i++) push_word(32'hA000_0000 + i);
        rd_reg(A_STAT, v); check("R4 full flags", v, exp_stat());

        // R7 overrun
        push_word(32'hEEEE_EEEE);
        rd_reg(A_STAT, v); check("R7 overrun flag", v, exp_stat());
        rd_reg(A_CNT, v);  check("R7 word dropped", v, 32'd64);

        // R9 write-one-to-clear
        wr_reg(A_STAT, 32'h0040_0000);
        rd_reg(A_STAT, v); check("R9 zero leaves bit", v, exp_stat());
        wr_reg(A_STAT, 32'h0080_0000); m_ovf = 1'b0;
        rd_reg(A_STAT, v); check("R9 one clears bit", v, exp_stat());

        // R3 drain in order
        for (int i = 0; i < 64; i++) begin
            reg_addr = A_DATA;
            rd_reg(A_DATA, v);
        end
        rd_reg(A_STAT, v); check("R4 empty flags", v, exp_stat());

        // R8 underrun
        rd_reg(A_DATA, v);
        rd_reg(A_STAT, v); check("R8 underrun flag", v, exp_stat());
        rd_reg(A_CNT, v);  check("R8 count unchanged", v, 32'h0);

        // R10 FIFO reset
        push_word(32'hB000_0000); push_word(32'hB000_0001);
        ctrl_write(32'h24);
        rd_reg(A_CNT, v);  check("R10 flushed", v, 32'h0);
        rd_reg(A_STAT, v); check("R10 errors cleared", v, exp_stat());
        rd_reg(A_LVL, v);  check("R10 levels kept", v, 32'h0003_0002);
        push_word(32'hB000_0002);
        rd_reg(A_CNT, v);  check("R10 enable kept", v, 32'h1);
        rd_reg(A_DATA, v);

        // R11 board reset and settling
        push_word(32'hC000_0000);
        ctrl_write(32'h21);
        rd_reg(A_LVL, v);  check("R11 levels default", v, 32'h0020_0020);
        rd_reg(A_CTRL, v); check("R11 enable cleared", v, 32'h0);
        rd_reg(A_CNT, v);  check("R11 flushed", v, 32'h0);
        ctrl_write(32'h20);
        push_word(32'hC000_0001);
        rd_reg(A_CNT, v);  check("R11 push blocked", v, 32'h0);
        rd_reg(A_DATA, v);
        rd_reg(A_STAT, v); check("R11 no underrun while settling", v, exp_stat());
        repeat (SETTLE + 20) @(negedge clk);
        m_settle = 1'b0;
        push_word(32'h5A5A_0001);
        rd_reg(A_CNT, v);  check("R11 accepts after interval", v, 32'h1);
        rd_reg(A_DATA, v);
        rd_reg(A_STAT, v); check("R11 status after drain", v, exp_stat());

        repeat (2) @(negedge clk);
        report();
    end

endmodule